// File: doc/BRIEF.md
# Snooping Write-Through Coherent L1 Cache

This block is a private level-one cache for one core in a small shared-memory multiprocessor. It is direct-mapped and write-through, so it never holds dirty data. Coherence comes only from invalidation: the cache watches every write the bus carries and drops its own copy of any line that another core writes.

The CPU side is blocking. The core raises a request for a byte, halfword or word read or write and holds it until `cpu_done` pulses, with `cpu_stall` high in the meantime. A read miss fetches the whole line over the shared bus in four word beats. Every store goes out on the bus as a single write with byte lanes. A store that hits also updates the cached copy. A store that misses leaves the cache untouched.

The tag and data stores are dual-ported. A snoop invalidation is therefore applied in the same cycle as a CPU lookup or a fill write, and neither one waits for the other.

Top module: `l1c_snoop_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_done` and `bus_req` are low, and the first read of any address causes a line fill.
- R2: A read miss raises `bus_req` with `bus_we`=0 and `bus_addr` equal to the line base (the low 4 address bits are zero), and holds the request until `bus_gnt`. It then takes four `bus_rvalid` words in ascending order and returns the requested data. Later reads within that line hit with no bus traffic, and `cpu_done` rises one cycle after the request is sampled.
- R3: Size code 0 is a byte, 1 a halfword and 2 (or 3) a word. Read data is right-justified and zero-extended. Byte lanes are little-endian: a byte is chosen by address bits [1:0], a halfword by address bit 1 (0 selects the low half), and a word ignores bits [1:0].
- R4: Every store issues exactly one bus write at the word-aligned address. `bus_be` is 1<<addr[1:0] for a byte, 0011 or 1100 for a halfword (by address bit 1), and 1111 for a word. `bus_wdata` holds the store data replicated across all lanes. `cpu_done` follows one cycle after the grant.
- R5: A store that hits changes only the enabled bytes of the cached word. A following read returns the merged word without a fill.
- R6: A store that misses does not allocate a line. A later read of that line still fills.
- R7: A snoop from another source whose tag and index match a valid line invalidates that line, so the next read of it fills again. A snoop to the same index with a different tag leaves the line valid.
- R8: A snoop whose source id equals `CORE_ID` is ignored.
- R9: A matching snoop that arrives while that line is being filled prevents the line from becoming valid. The read still completes with the fetched data, and the next read of the line fills again.
- R10: A read hit and a snoop invalidation of a different line in the same cycle both take effect. The read completes with normal hit latency, and the other line is invalid afterwards.
- R11: `cpu_stall` is high while a request is pending and not done, and low in the cycle `cpu_done` is high. `cpu_done` lasts one cycle.
- R12: Two addresses that share an index but differ in tag evict each other, so alternating reads of them fill every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU request, held until done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Store data, right-justified |
| cpu_rdata | output | 32 | Load data, right-justified, zero-extended |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | High while a request is outstanding |
| bus_req | output | 1 | Bus request, held until granted |
| bus_we | output | 1 | 1 = write-through, 0 = line fill |
| bus_addr | output | ADDR_W | Line base for fills, word address for writes |
| bus_wdata | output | 32 | Write data, replicated across lanes |
| bus_be | output | 4 | Byte-lane enables |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_rvalid | input | 1 | Fill word valid |
| bus_rdata | input | 32 | Fill word |
| snp_valid | input | 1 | A write was issued on the bus this cycle |
| snp_addr | input | ADDR_W | Address of that write |
| snp_src | input | SRC_W | Id of the core that issued it |

## Verification
The main function is tried with several access patterns, and each one separates a different possible fault.

- Cold reads expose a missing fill or a fill at the wrong address.
- Repeated reads within one line catch a cache that never hits.
- Sub-word reads and stores at every lane offset catch wrong lane steering and wrong byte enables.
- Store-then-load pairs on hit and miss addresses tell a write-allocate cache from one that correctly does not allocate.
- Foreign snoops to the cached tag, to a different tag at the same index and from the core's own id tell real tag matching from a coarse index-only or self-invalidating scheme.
- A snoop landing in the middle of a fill, and a snoop coinciding with a read hit, show whether the two store ports really work concurrently and whether a stale fill can become valid.

// File: rtl/l1c_pkg.sv
`timescale 1ns/1ps
package l1c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FILL_REQ,
      ST_FILL_DATA,
      ST_WT_REQ,
      ST_RESP
   } l1c_state_e;

   // byte-lane enables for an access of a given size at a given offset
   function automatic logic [3:0] l1c_lanes(input logic [1:0] sz, input logic [1:0] a);
      case (sz)
         2'd0:    return 4'b0001 << a;
         2'd1:    return a[1] ? 4'b1100 : 4'b0011;
         default: return 4'b1111;
      endcase
   endfunction

   // replicate right-justified store data across all lanes
   function automatic logic [31:0] l1c_spread(input logic [1:0] sz, input logic [31:0] d);
      case (sz)
         2'd0:    return {4{d[7:0]}};
         2'd1:    return {2{d[15:0]}};
         default: return d;
      endcase
   endfunction

   // pull the addressed field out of a word, right-justified
   function automatic logic [31:0] l1c_pick(input logic [1:0] sz, input logic [1:0] a,
                                            input logic [31:0] w);
      case (sz)
         2'd0:    return {24'd0, w[{a, 3'b000} +: 8]};
         2'd1:    return {16'd0, (a[1] ? w[31:16] : w[15:0])};
         default: return w;
      endcase
   endfunction

endpackage

// File: rtl/l1c_tag_store.sv
`timescale 1ns/1ps
module l1c_tag_store #(
   parameter int IDX_W = 9,
   parameter int TAG_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   output logic [TAG_W-1:0] lk_tag,
   output logic             lk_valid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_valid,
   input  logic             snp_en,
   input  logic [IDX_W-1:0] snp_idx,
   input  logic [TAG_W-1:0] snp_tag
);
   localparam int LINES = 1 << IDX_W;

   logic [TAG_W-1:0] tags [LINES];
   logic [LINES-1:0] valid;
   logic             snp_hit;

   assign lk_tag   = tags[lk_idx];
   assign lk_valid = valid[lk_idx];
   assign snp_hit  = snp_en && valid[snp_idx] && (tags[snp_idx] == snp_tag);

   always_ff @(posedge clk) begin
      if (wr_en) tags[wr_idx] <= wr_tag;
   end

   // port A: fill writes; port B: snoop invalidation (applied last)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= '0;
      end else begin
         if (wr_en)   valid[wr_idx]  <= wr_valid;
         if (snp_hit) valid[snp_idx] <= 1'b0;
      end
   end
endmodule

// File: rtl/l1c_data_store.sv
`timescale 1ns/1ps
module l1c_data_store #(
   parameter int IDX_W  = 9,
   parameter int WSEL_W = 2
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WSEL_W-1:0] rd_wsel,
   output logic [31:0]       rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_wsel,
   input  logic [3:0]        wr_be,
   input  logic [31:0]       wr_data
);
   localparam int AW    = IDX_W + WSEL_W;
   localparam int DEPTH = 1 << AW;

   logic [AW-1:0] rd_a, wr_a;
   assign rd_a = {rd_idx, rd_wsel};
   assign wr_a = {wr_idx, wr_wsel};

   for (genvar g = 0; g < 4; g++) begin : g_lane
      logic [7:0] arr [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && wr_be[g]) arr[wr_a] <= wr_data[8*g +: 8];
      end
      assign rd_data[8*g +: 8] = arr[rd_a];
   end
endmodule

// File: rtl/l1c_ctrl.sv
`timescale 1ns/1ps
module l1c_ctrl import l1c_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4,
   parameter int IDX_W  = 9,
   parameter int WSEL_W = 2,
   parameter int TAG_W  = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [31:0]       cpu_wdata,
   output logic              cpu_done,
   output logic [31:0]       cpu_rdata,
   input  logic              lk_valid,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic [31:0]       rd_word,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   output logic [3:0]        bus_be,
   input  logic              bus_gnt,
   input  logic              bus_rvalid,
   input  logic [31:0]       bus_rdata,
   input  logic              snp_fg,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              tw_en,
   output logic [IDX_W-1:0]  tw_idx,
   output logic [TAG_W-1:0]  tw_tag,
   output logic              tw_valid,
   output logic              dw_en,
   output logic [IDX_W-1:0]  dw_idx,
   output logic [WSEL_W-1:0] dw_wsel,
   output logic [3:0]        dw_be,
   output logic [31:0]       dw_data
);
   l1c_state_e        state, nxt;
   logic [WSEL_W-1:0] cnt;
   logic              cnt_clr, cnt_inc;
   logic              cancel, cancel_d;
   logic [31:0]       crit;
   logic              crit_ld;
   logic [31:0]       rdata_q, rdata_d;
   logic              rd_ld;

   logic [IDX_W-1:0]  cur_idx;
   logic [TAG_W-1:0]  cur_tag;
   logic [WSEL_W-1:0] cur_wsel;
   logic              hit, snp_fill_hit, last_beat;

   assign cur_idx  = cpu_addr[OFF_W +: IDX_W];
   assign cur_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
   assign cur_wsel = cpu_addr[2 +: WSEL_W];
   assign hit      = lk_valid && (lk_tag == cur_tag);
   assign last_beat = &cnt;

   // a foreign write to the very line now being fetched
   assign snp_fill_hit = snp_fg && (snp_addr[OFF_W +: IDX_W] == cur_idx)
                                && (snp_addr[ADDR_W-1 -: TAG_W] == cur_tag);

   assign cpu_done  = (state == ST_RESP);
   assign cpu_rdata = rdata_q;

   always_comb begin
      nxt       = state;
      cnt_clr   = 1'b0;
      cnt_inc   = 1'b0;
      cancel_d  = cancel;
      crit_ld   = 1'b0;
      rd_ld     = 1'b0;
      rdata_d   = rdata_q;
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      bus_be    = 4'b0000;
      tw_en     = 1'b0;
      tw_idx    = cur_idx;
      tw_tag    = cur_tag;
      tw_valid  = 1'b0;
      dw_en     = 1'b0;
      dw_idx    = cur_idx;
      dw_wsel   = cur_wsel;
      dw_be     = 4'b1111;
      dw_data   = bus_rdata;
      case (state)
         ST_IDLE: begin
            if (cpu_req) begin
               if (cpu_we) begin
                  nxt = ST_WT_REQ;
               end else if (hit) begin
                  rd_ld   = 1'b1;
                  rdata_d = l1c_pick(cpu_size, cpu_addr[1:0], rd_word);
                  nxt     = ST_RESP;
               end else begin
                  nxt = ST_FILL_REQ;
               end
            end
         end
         ST_FILL_REQ: begin
            bus_req  = 1'b1;
            bus_addr = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            bus_be   = 4'b1111;
            if (bus_gnt) begin
               tw_en    = 1'b1;          // old contents are about to be overwritten
               tw_valid = 1'b0;
               cnt_clr  = 1'b1;
               cancel_d = snp_fill_hit;
               nxt      = ST_FILL_DATA;
            end
         end
         ST_FILL_DATA: begin
            cancel_d = cancel | snp_fill_hit;
            if (bus_rvalid) begin
               dw_en   = 1'b1;
               dw_wsel = cnt;
               if (cnt == cur_wsel) crit_ld = 1'b1;
               if (last_beat) begin
                  tw_en    = 1'b1;
                  tw_valid = !(cancel | snp_fill_hit);
                  rd_ld    = 1'b1;
                  rdata_d  = l1c_pick(cpu_size, cpu_addr[1:0],
                                      (cnt == cur_wsel) ? bus_rdata : crit);
                  nxt      = ST_RESP;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
         end
         ST_WT_REQ: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = {cpu_addr[ADDR_W-1:2], 2'b00};
            bus_wdata = l1c_spread(cpu_size, cpu_wdata);
            bus_be    = l1c_lanes(cpu_size, cpu_addr[1:0]);
            if (bus_gnt) begin
               dw_en   = hit;             // no allocation on a miss
               dw_be   = bus_be;
               dw_data = bus_wdata;
               nxt     = ST_RESP;
            end
         end
         ST_RESP: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         cancel  <= 1'b0;
         crit    <= '0;
         rdata_q <= '0;
      end else begin
         state  <= nxt;
         cancel <= cancel_d;
         if (cnt_clr)      cnt <= '0;
         else if (cnt_inc) cnt <= cnt + 1'b1;
         if (crit_ld) crit    <= bus_rdata;
         if (rd_ld)   rdata_q <= rdata_d;
      end
   end
endmodule

// File: rtl/l1c_snoop_cache.sv
`timescale 1ns/1ps
module l1c_snoop_cache import l1c_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int CAP_BYTES  = 8192,
   parameter int LINE_BYTES = 16,
   parameter int SRC_W      = 3,
   parameter int CORE_ID    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [31:0]       cpu_wdata,
   output logic [31:0]       cpu_rdata,
   output logic              cpu_done,
   output logic              cpu_stall,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   output logic [3:0]        bus_be,
   input  logic              bus_gnt,
   input  logic              bus_rvalid,
   input  logic [31:0]       bus_rdata,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [SRC_W-1:0]  snp_src
);
   localparam int LINES  = CAP_BYTES / LINE_BYTES;
   localparam int WPL    = LINE_BYTES / 4;
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int WSEL_W = $clog2(WPL);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

   // elaboration-time parameter checks
   if (LINE_BYTES < 8 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 8");
   end
   if ((CAP_BYTES % LINE_BYTES) != 0 || (LINES & (LINES - 1)) != 0 || LINES < 2) begin : g_bad_cap
      $error("CAP_BYTES must hold a power-of-two number of lines");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the chosen geometry");
   end
   if (CORE_ID < 0 || CORE_ID >= (1 << SRC_W)) begin : g_bad_id
      $error("CORE_ID does not fit in SRC_W bits");
   end

   logic              lk_valid;
   logic [TAG_W-1:0]  lk_tag;
   logic [31:0]       rd_word;
   logic              tw_en, tw_valid;
   logic [IDX_W-1:0]  tw_idx;
   logic [TAG_W-1:0]  tw_tag;
   logic              dw_en;
   logic [IDX_W-1:0]  dw_idx;
   logic [WSEL_W-1:0] dw_wsel;
   logic [3:0]        dw_be;
   logic [31:0]       dw_data;
   logic              snp_fg;
   logic              unused_snp_low;

   // writes this core issued itself are not invalidation sources
   assign snp_fg         = snp_valid && (snp_src != SRC_W'(CORE_ID));
   assign unused_snp_low = ^snp_addr[OFF_W-1:0];
   assign cpu_stall      = cpu_req && !cpu_done;

   l1c_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (cpu_addr[OFF_W +: IDX_W]),
      .lk_tag   (lk_tag),
      .lk_valid (lk_valid),
      .wr_en    (tw_en),
      .wr_idx   (tw_idx),
      .wr_tag   (tw_tag),
      .wr_valid (tw_valid),
      .snp_en   (snp_fg),
      .snp_idx  (snp_addr[OFF_W +: IDX_W]),
      .snp_tag  (snp_addr[ADDR_W-1 -: TAG_W])
   );

   l1c_data_store #(.IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
      .clk     (clk),
      .rd_idx  (cpu_addr[OFF_W +: IDX_W]),
      .rd_wsel (cpu_addr[2 +: WSEL_W]),
      .rd_data (rd_word),
      .wr_en   (dw_en),
      .wr_idx  (dw_idx),
      .wr_wsel (dw_wsel),
      .wr_be   (dw_be),
      .wr_data (dw_data)
   );

   l1c_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W),
              .TAG_W(TAG_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .cpu_size   (cpu_size),
      .cpu_addr   (cpu_addr),
      .cpu_wdata  (cpu_wdata),
      .cpu_done   (cpu_done),
      .cpu_rdata  (cpu_rdata),
      .lk_valid   (lk_valid),
      .lk_tag     (lk_tag),
      .rd_word    (rd_word),
      .bus_req    (bus_req),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_be     (bus_be),
      .bus_gnt    (bus_gnt),
      .bus_rvalid (bus_rvalid),
      .bus_rdata  (bus_rdata),
      .snp_fg     (snp_fg),
      .snp_addr   (snp_addr),
      .tw_en      (tw_en),
      .tw_idx     (tw_idx),
      .tw_tag     (tw_tag),
      .tw_valid   (tw_valid),
      .dw_en      (dw_en),
      .dw_idx     (dw_idx),
      .dw_wsel    (dw_wsel),
      .dw_be      (dw_be),
      .dw_data    (dw_data)
   );
endmodule

// File: rtl/l1c_checker.sv
`timescale 1ns/1ps
module l1c_checker #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_done,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [3:0]        bus_be,
   input logic              bus_gnt,
   input logic              bus_rvalid
);
   // R2: an ungranted request is held with the same address and direction
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we));

   // R2: fills are requested at a line boundary
   p_fill_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_we |-> bus_addr[OFF_W-1:0] == '0);

   // R4: write-through is word aligned with at least one lane enabled
   p_wt_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we |-> (bus_addr[1:0] == 2'b00) && (bus_be != 4'b0000));

   // R11: completion is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   // R11: no completion while the bus transaction is still open
   p_no_early_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req || bus_rvalid) |-> !cpu_done);
endmodule

bind l1c_snoop_cache l1c_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_done   (cpu_done),
   .bus_req    (bus_req),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_be     (bus_be),
   .bus_gnt    (bus_gnt),
   .bus_rvalid (bus_rvalid)
);

// File: tb/sim_l1c_snoop_cache.sv
`timescale 1ns/1ps
module sim_l1c_snoop_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [1:0]  cpu_size = 2'd2;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_done, cpu_stall;
   logic        bus_req, bus_we;
   logic [31:0] bus_addr, bus_wdata;
   logic [3:0]  bus_be;
   logic        bus_gnt = 1'b0, bus_rvalid = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic        snp_valid = 1'b0;
   logic [31:0] snp_addr = '0;
   logic [2:0]  snp_src = '0;

   int          n_cmp = 0, n_bad = 0;
   int          fills = 0, stall_bad = 0, bus_lat = 0;
   logic        cur_we = 1'b0;
   logic [31:0] last_waddr, last_wdata;
   logic [3:0]  last_be;
   logic [31:0] mem [logic [29:0]];
   logic [31:0] exp_val [$];
   string       exp_tag [$];

   always #2 clk = ~clk;   // 250 MHz

   l1c_snoop_cache u0 (.*);

   function automatic logic [31:0] mword(input logic [31:0] a);
      if (mem.exists(a[31:2])) return mem[a[31:2]];
      return ({a[31:2], 2'b00} * 32'h0101_0101) ^ 32'hA5C3_9E17;
   endfunction

   function automatic logic [31:0] field(input logic [1:0] sz, input logic [31:0] a,
                                         input logic [31:0] w);
      if (sz == 2'd0) return {24'd0, w[8*a[1:0] +: 8]};
      if (sz == 2'd1) return a[1] ? {16'd0, w[31:16]} : {16'd0, w[15:0]};
      return w;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // bus model: grant after bus_lat cycles, four fill beats after a read grant
   initial begin
      int waitc = 0;
      logic rd_pend = 1'b0;
      logic [31:0] base = '0;
      forever begin
         @(negedge clk);
         if (bus_gnt) begin
            bus_gnt = 1'b0;
            if (rd_pend) begin
               for (int i = 0; i < 4; i++) begin
                  bus_rvalid = 1'b1;
                  bus_rdata  = mword(base + 32'(4*i));
                  @(negedge clk);
               end
               bus_rvalid = 1'b0;
               rd_pend    = 1'b0;
            end
         end else if (bus_req) begin
            if (waitc < bus_lat) begin
               waitc++;
            end else begin
               waitc   = 0;
               bus_gnt = 1'b1;
               if (bus_we) begin
                  logic [31:0] w;
                  last_waddr = bus_addr; last_be = bus_be; last_wdata = bus_wdata;
                  w = mword(bus_addr);
                  for (int b = 0; b < 4; b++)
                     if (bus_be[b]) w[8*b +: 8] = bus_wdata[8*b +: 8];
                  mem[bus_addr[31:2]] = w;
               end else begin
                  rd_pend = 1'b1;
                  base    = bus_addr;
                  fills++;
               end
            end
         end
      end
   end

   // monitor: compare every load completion against the scoreboard
   initial forever begin
      @(negedge clk);
      if (rst_n && cpu_done && !cur_we) begin
         if (exp_val.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: actual unexpected completion expected none");
         end else begin
            string t;
            logic [31:0] e;
            e = exp_val.pop_front();
            t = exp_tag.pop_front();
            chk(t, cpu_rdata, e);
         end
      end
   end

   // driver: issue one access, push the expected load value, wait for done
   task automatic cpu_op(input string tag, input logic we, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] wd, output int lat);
      if (!we) begin
         exp_val.push_back(field(sz, a, mword(a)));
         exp_tag.push_back(tag);
      end
      cur_we = we; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
      cpu_req = 1'b1;
      lat = 0;
      do begin
         @(posedge clk); lat++;
         @(negedge clk);
         if (!cpu_done && !cpu_stall) stall_bad++;
      end while (!cpu_done);
      if (cpu_stall) stall_bad++;   // R11
      cpu_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic snoop(input logic [31:0] a, input logic [2:0] src);
      snp_valid = 1'b1; snp_addr = a; snp_src = src;
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   localparam logic [31:0] A = 32'h0000_1040;
   localparam logic [31:0] B = 32'h0000_3040;   // same index as A
   localparam logic [31:0] C = 32'h0000_3100;
   localparam logic [31:0] D = 32'h0000_0200;

   initial begin
      int lat, f0;
      repeat (3) @(negedge clk);
      chk("R1 done after reset", 32'(cpu_done), 0);
      chk("R1 bus_req after reset", 32'(bus_req), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // cold read of a word, bus slow to grant
      bus_lat = 2;
      f0 = fills;
      cpu_op("R2 cold word read", 0, 2'd2, A + 32'd4, 0, lat);
      chk("R1 first read fills", 32'(fills - f0), 1);
      bus_lat = 0;

      f0 = fills;
      cpu_op("R2 hit word read", 0, 2'd2, A + 32'd8, 0, lat);
      chk("R2 hit needs no fill", 32'(fills - f0), 0);
      chk("R2 hit latency", 32'(lat), 1);

      cpu_op("R3 byte lane1", 0, 2'd0, A + 32'd5, 0, lat);
      cpu_op("R3 byte lane3", 0, 2'd0, A + 32'd3, 0, lat);
      cpu_op("R3 half upper", 0, 2'd1, A + 32'd6, 0, lat);
      cpu_op("R3 half lower", 0, 2'd1, A + 32'd12, 0, lat);
      cpu_op("R3 word ignores low bits", 0, 2'd2, A + 32'd15, 0, lat);

      // byte store that hits
      f0 = fills;
      cpu_op("R4 byte store", 1, 2'd0, A + 32'd9, 32'h0000_00EE, lat);
      chk("R4 store word address", last_waddr, A + 32'd8);
      chk("R4 byte lanes", 32'(last_be), 32'h2);
      chk("R4 replicated data", last_wdata, 32'hEEEE_EEEE);
      cpu_op("R5 merged word", 0, 2'd2, A + 32'd8, 0, lat);
      chk("R5 no fill after store hit", 32'(fills - f0), 0);

      bus_lat = 1;
      cpu_op("R4 half store", 1, 2'd1, A + 32'd14, 32'h0000_BEEF, lat);
      chk("R4 half lanes", 32'(last_be), 32'hC);
      cpu_op("R4 word store", 1, 2'd2, A, 32'h1122_3344, lat);
      chk("R4 word lanes", 32'(last_be), 32'hF);
      bus_lat = 0;
      cpu_op("R5 half merged", 0, 2'd2, A + 32'd12, 0, lat);
      cpu_op("R5 word stored", 0, 2'd2, A, 0, lat);

      // store that misses must not allocate
      f0 = fills;
      cpu_op("R6 store miss", 1, 2'd2, C + 32'd4, 32'hCAFE_F00D, lat);
      chk("R6 no fill on store miss", 32'(fills - f0), 0);
      cpu_op("R6 read after store miss", 0, 2'd2, C + 32'd4, 0, lat);
      chk("R6 read fills", 32'(fills - f0), 1);

      // foreign write to cached line
      mem[(A + 32'd4) >> 2] = 32'h1234_5678;
      snoop(A + 32'd4, 3'd3);
      f0 = fills;
      cpu_op("R7 new value after snoop", 0, 2'd2, A + 32'd4, 0, lat);
      chk("R7 snooped line refilled", 32'(fills - f0), 1);
      snoop(B, 3'd5);
      f0 = fills;
      cpu_op("R7 other tag kept", 0, 2'd2, A, 0, lat);
      chk("R7 other-tag snoop kept line", 32'(fills - f0), 0);

      // own-source snoop ignored
      snoop(A, 3'd0);
      f0 = fills;
      cpu_op("R8 own snoop read", 0, 2'd2, A, 0, lat);
      chk("R8 own snoop ignored", 32'(fills - f0), 0);

      // conflict eviction
      f0 = fills;
      cpu_op("R12 read B", 0, 2'd2, B, 0, lat);
      cpu_op("R12 read A", 0, 2'd2, A + 32'd8, 0, lat);
      chk("R12 alternating fills", 32'(fills - f0), 2);

      // snoop during a fill of the same line
      f0 = fills;
      fork
         cpu_op("R9 data during cancelled fill", 0, 2'd2, D + 32'd8, 0, lat);
         begin
            do @(negedge clk); while (!bus_rvalid);
            snoop(D, 3'd2);
         end
      join
      cpu_op("R9 reread", 0, 2'd2, D, 0, lat);
      chk("R9 cancelled fill left line invalid", 32'(fills - f0), 2);

      // read hit concurrent with an invalidation of another line
      fork
         cpu_op("R10 concurrent hit", 0, 2'd2, D + 32'd4, 0, lat);
         snoop(A + 32'd8, 3'd1);
      join
      chk("R10 hit latency with snoop", 32'(lat), 1);
      f0 = fills;
      cpu_op("R10 other line refetched", 0, 2'd2, A, 0, lat);
      chk("R10 other line invalidated", 32'(fills - f0), 1);

      chk("R11 stall violations", 32'(stall_bad), 0);
      chk("R2 scoreboard drained", 32'(exp_val.size()), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule